// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers six interrupt sources: two active-low external pins, overflow pulses from three timers, and the receive/transmit flags of a serial port. It masks them through an 8-bit enable register and picks one pending source in a fixed order. It presents that source's vector address to the CPU. The CPU answers with a one-cycle acknowledge when it takes the vector. The controller then clears the hardware flag of that source where the rules call for it. It issues nothing further until a return-from-interrupt pulse arrives.

Each external pin can be set, through its own trigger-type bit, to react to the pin level or to a falling edge. An edge is held in a flag until the CPU takes it. Timer overflows are latched in the same way. The serial request is the OR of the port's two flags. The controller never clears those flags, so serial software has to clear them.

Top module: `intc_vectored`

## Requirements
- R1: After reset `irq_req` is 0 and `irq_vector` is 0000h. The enable register resets to 00h.
- R2: When enable bit 7 (global) is 0, `irq_req` stays 0 whatever the other enable bits and sources are.
- R3: Enable bit k (k = 0..5) masks source k. The source order is: 0 external pin 0, 1 timer 0, 2 external pin 1, 3 timer 1, 4 serial, 5 timer 2. Bit 6 has no effect. A masked source stays pending and raises a request once its bit is set.
- R4: While `irq_req` is 1, `irq_vector` equals 0003h + 8·k for the selected source k. While `irq_req` is 0, it reads 0000h.
- R5: When several enabled sources are pending, the one with the lowest index k is selected.
- R6: With trigger bit 1 (edge mode), a falling edge on the external pin, sampled on consecutive clocks, sets a flag. The flag holds after the pin returns high and is cleared when that source is acknowledged.
- R7: With trigger bit 0 (level mode), the external request follows the inverted pin in the same cycle and is not latched.
- R8: A one-cycle timer overflow pulse sets that timer's flag on the next clock edge. The flag is cleared when that source is acknowledged.
- R9: The serial request is the OR of `ser_rx_flag` and `ser_tx_flag`. An acknowledge does not clear it.
- R10: An acknowledge while `irq_req` is 1 enters service. `irq_req` then stays 0 until an `irq_reti` pulse ends service.
- R11: An acknowledge clears only the flag of the selected source. Other pending flags remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin_n | input | 2 | Active-low external interrupt pins |
| ext_edge_mode | input | 2 | Per pin: 1 falling-edge, 0 level |
| tmr_ovf | input | 3 | Overflow pulses of timers 0, 1, 2 |
| ser_rx_flag | input | 1 | Serial receive-complete flag |
| ser_tx_flag | input | 1 | Serial transmit-complete flag |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vector | output | 16 | Vector address of the selected source |
| irq_ack | input | 1 | CPU has taken the vector (one cycle) |
| irq_reti | input | 1 | Return-from-interrupt pulse |

## Verification
The assertions assume that every input is synchronous to `clk`, that timer overflows are single-cycle pulses, and that the CPU pulses `irq_ack` for one cycle and `irq_reti` only after an acknowledge. The stimulus changes inputs only on the falling clock edge. It holds each acknowledge and return pulse for exactly one cycle, and it clears the serial flags itself before each return, as serial software would. The sweeps cover every single source, every pair of sources, each enable mask, and both trigger modes.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC   = 6;
  localparam int SRC_IDX_W = 3;
  localparam int VEC_W     = 16;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  typedef enum logic [SRC_IDX_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4,
    SRC_TMR2 = 3'd5
  } src_id_e;

  // index of the lowest set bit (lowest index wins)
  function automatic logic [SRC_IDX_W-1:0] lowest_set(input src_vec_t m);
    logic [SRC_IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (m[i]) r = SRC_IDX_W'(i);
    end
    return r;
  endfunction

  // vector address: base plus index times spacing
  function automatic logic [VEC_W-1:0] vector_of(input logic [SRC_IDX_W-1:0] idx,
                                                 input logic [VEC_W-1:0] base,
                                                 input logic [VEC_W-1:0] step);
    logic [VEC_W-1:0] idx_w;
    idx_w = VEC_W'(idx);
    return base + step * idx_w;
  endfunction
endpackage

// File: rtl/intc_ext_src.sv
module intc_ext_src (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic pin_q;
  logic flag;
  logic fall;

  assign fall = pin_q & ~pin_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b1;
      flag  <= 1'b0;
    end else begin
      pin_q <= pin_n;
      flag  <= edge_mode & (fall | (flag & ~clr));
    end
  end

  assign req = edge_mode ? flag : ~pin_n;

  assert_edge_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && fall) |=> flag);
  assert_edge_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && flag && !clr) |=> flag);
  assert_level_nolatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode |=> !flag);
endmodule

// File: rtl/intc_tmr_flag.sv
module intc_tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic clr,
  output logic req
);
  logic flag;

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= ovf | (flag & ~clr);
  end

  assign req = flag;

  assert_ovf_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> req);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ovf) |=> !req);
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0003,
  parameter logic [VEC_W-1:0] VEC_STEP = 16'h0008
) (
  input  logic             clk,
  input  logic             rst_n,
  input  src_vec_t         src_req,
  input  logic             en_wr,
  input  logic [7:0]       en_wdata,
  input  logic             irq_ack,
  input  logic             irq_reti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vector,
  output src_vec_t         src_clr
);
  localparam int GLOBAL_BIT = 7;

  logic                 en_global;
  src_vec_t             en_src;
  logic                 in_service;
  src_vec_t             armed;
  src_vec_t             grant;
  logic [SRC_IDX_W-1:0] sel_idx;
  logic                 any_armed;
  logic                 take;
  logic                 unused_reserved;

  assign unused_reserved = en_wdata[6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_global <= 1'b0;
      en_src    <= '0;
    end else if (en_wr) begin
      en_global <= en_wdata[GLOBAL_BIT];
      en_src    <= en_wdata[NUM_SRC-1:0];
    end
  end

  assign armed     = src_req & en_src;
  assign any_armed = |armed;
  assign sel_idx   = lowest_set(armed);
  assign grant     = any_armed ? (src_vec_t'(1) << sel_idx) : '0;
  assign irq_req   = en_global & any_armed & ~in_service;
  assign take      = irq_ack & irq_req;
  assign src_clr   = take ? grant : '0;
  assign irq_vector = irq_req ? vector_of(sel_idx, VEC_BASE, VEC_STEP) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)        in_service <= 1'b0;
    else if (take)     in_service <= 1'b1;
    else if (irq_reti) in_service <= 1'b0;
  end

  assert_global_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_global |-> !irq_req);
  assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_clr));
  assert_enter_service_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (in_service && !irq_req));
  assert_hold_service_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service && !irq_reti) |=> !irq_req);
endmodule

// File: rtl/intc_vectored.sv
module intc_vectored
  import intc_pkg::*;
#(
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter logic [15:0] VEC_STEP = 16'h0008
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ext_pin_n,
  input  logic [1:0]  ext_edge_mode,
  input  logic [2:0]  tmr_ovf,
  input  logic        ser_rx_flag,
  input  logic        ser_tx_flag,
  input  logic        en_wr,
  input  logic [7:0]  en_wdata,
  output logic        irq_req,
  output logic [15:0] irq_vector,
  input  logic        irq_ack,
  input  logic        irq_reti
);
  localparam int NUM_EXT = 2;
  localparam int NUM_TMR = 3;

  localparam int EXT_SLOT [NUM_EXT] = '{int'(SRC_EXT0), int'(SRC_EXT1)};
  localparam int TMR_SLOT [NUM_TMR] = '{int'(SRC_TMR0), int'(SRC_TMR1), int'(SRC_TMR2)};

  src_vec_t src_req;
  src_vec_t src_clr;
  logic     unused_ser_clr;

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
    intc_ext_src u_ext (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_n     (ext_pin_n[e]),
      .edge_mode (ext_edge_mode[e]),
      .clr       (src_clr[EXT_SLOT[e]]),
      .req       (src_req[EXT_SLOT[e]])
    );
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    intc_tmr_flag u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .ovf   (tmr_ovf[t]),
      .clr   (src_clr[TMR_SLOT[t]]),
      .req   (src_req[TMR_SLOT[t]])
    );
  end

  // serial request is never cleared here
  assign src_req[SRC_SER] = ser_rx_flag | ser_tx_flag;
  assign unused_ser_clr   = src_clr[SRC_SER];

  intc_arbiter #(
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_req    (src_req),
    .en_wr      (en_wr),
    .en_wdata   (en_wdata),
    .irq_ack    (irq_ack),
    .irq_reti   (irq_reti),
    .irq_req    (irq_req),
    .irq_vector (irq_vector),
    .src_clr    (src_clr)
  );

  assert_vector_grid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (((irq_vector - VEC_BASE) % VEC_STEP) == 16'd0));
  assert_idle_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vector == 16'h0000));
  assert_serial_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && ser_rx_flag) |-> src_req[SRC_SER]);
endmodule

// File: tb/test_intc_vectored.sv
module test_intc_vectored;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ext_pin_n = 2'b11;
  logic [1:0]  ext_edge_mode = 2'b11;
  logic [2:0]  tmr_ovf = 3'b000;
  logic        ser_rx_flag = 1'b0;
  logic        ser_tx_flag = 1'b0;
  logic        en_wr = 1'b0;
  logic [7:0]  en_wdata = 8'h00;
  logic        irq_req;
  logic [15:0] irq_vector;
  logic        irq_ack = 1'b0;
  logic        irq_reti = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_vectored i_intc_vectored (
    .clk, .rst_n, .ext_pin_n, .ext_edge_mode, .tmr_ovf,
    .ser_rx_flag, .ser_tx_flag, .en_wr, .en_wdata,
    .irq_req, .irq_vector, .irq_ack, .irq_reti
  );

  function automatic logic [15:0] exp_vec(input int k);
    return 16'h0003 + 16'(k * 8);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_en(input logic [7:0] v);
    @(negedge clk); en_wr = 1'b1; en_wdata = v;
    @(negedge clk); en_wr = 1'b0;
    #1;
  endtask

  // source k: 0 pin0, 1 timer0, 2 pin1, 3 timer1, 4 serial, 5 timer2
  task automatic raise(input int k);
    @(negedge clk);
    case (k)
      0: ext_pin_n[0] = 1'b0;
      1: tmr_ovf[0] = 1'b1;
      2: ext_pin_n[1] = 1'b0;
      3: tmr_ovf[1] = 1'b1;
      4: ser_rx_flag = 1'b1;
      default: tmr_ovf[2] = 1'b1;
    endcase
    @(negedge clk);
    ext_pin_n = 2'b11;
    tmr_ovf = 3'b000;
    #1;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    #1;
  endtask

  task automatic reti();
    @(negedge clk); irq_reti = 1'b1;
    @(negedge clk); irq_reti = 1'b0;
    #1;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 req after reset", 16'(irq_req), 16'd0);
    chk("R1 vector after reset", irq_vector, 16'h0000);

    write_en(8'hBF);

    // R4/R8/R6: every single source
    for (int k = 0; k < 6; k++) begin
      raise(k);
      chk("R4 single req", 16'(irq_req), 16'd1);
      chk("R4 single vector", irq_vector, exp_vec(k));
      ack();
      chk("R10 in service", 16'(irq_req), 16'd0);
      if (k == 4) ser_rx_flag = 1'b0;
      reti();
      chk("R8 R6 flag cleared", 16'(irq_req), 16'd0);
    end

    // R5/R11: every pair
    for (int i = 0; i < 6; i++) begin
      for (int j = i + 1; j < 6; j++) begin
        raise(j);
        raise(i);
        chk("R5 pair winner", irq_vector, exp_vec(i));
        ack();
        if (i == 4) ser_rx_flag = 1'b0;
        reti();
        chk("R11 other kept", irq_vector, exp_vec(j));
        ack();
        if (j == 4) ser_rx_flag = 1'b0;
        reti();
        chk("R11 all served", 16'(irq_req), 16'd0);
      end
    end

    // R2: global gate
    write_en(8'h3F);
    raise(1);
    chk("R2 global off", 16'(irq_req), 16'd0);
    write_en(8'hBF);
    chk("R2 global on vector", irq_vector, exp_vec(1));
    ack(); reti();

    // R3: individual masks, bit 6 set to show it has no effect
    for (int k = 0; k < 6; k++) begin
      write_en(8'hC0 | (8'h3F & ~(8'h01 << k)));
      raise(k);
      chk("R3 masked", 16'(irq_req), 16'd0);
      write_en(8'h80 | (8'h01 << k));
      chk("R3 unmasked vector", irq_vector, exp_vec(k));
      ack();
      if (k == 4) ser_rx_flag = 1'b0;
      reti();
    end
    write_en(8'hBF);

    // R6: edge flag holds after pin returns high
    raise(2);
    repeat (3) @(negedge clk);
    #1;
    chk("R6 edge held", irq_vector, exp_vec(2));
    ack(); reti();
    chk("R6 edge cleared", 16'(irq_req), 16'd0);

    // R7: level mode follows pin
    @(negedge clk); ext_edge_mode = 2'b10;
    @(negedge clk); ext_pin_n[0] = 1'b0; #1;
    chk("R7 level active", irq_vector, exp_vec(0));
    @(negedge clk); ext_pin_n[0] = 1'b1; #1;
    chk("R7 level released", 16'(irq_req), 16'd0);
    @(negedge clk); ext_edge_mode = 2'b11; #1;

    // R9: serial OR, not cleared by acknowledge
    raise(4);
    ack(); reti();
    chk("R9 serial persists", irq_vector, exp_vec(4));
    @(negedge clk); ser_rx_flag = 1'b0; ser_tx_flag = 1'b1; #1;
    chk("R9 tx flag alone", irq_vector, exp_vec(4));
    @(negedge clk); ser_tx_flag = 1'b0; #1;
    chk("R9 both low", 16'(irq_req), 16'd0);

    // R10: higher source waits for return
    raise(3);
    ack();
    raise(0);
    chk("R10 blocked in service", 16'(irq_req), 16'd0);
    reti();
    chk("R10 after return", irq_vector, exp_vec(0));
    ack(); reti();
    chk("R10 nothing left", 16'(irq_req), 16'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule